// File: doc/BRIEF.md
# Receive-Side Boundary Cell with Sticky Integrity Flag

This block is one receive-side cell of a boundary-scan register, clocked by the test clock. It has the usual capture, shift and update stages. On top of them it holds a sticky violation flag that records any pulse from an external timing sensor placed at the far end of an interconnect. The sensor output has no fixed timing relation to the test clock. It passes through a synchronizer and then drives a two-state flag machine (`FLAG_CLEAR`, `FLAG_SET`).

When the integrity-select input is high, a capture strobe loads the flag into the shift stage in place of the pin value, and the same capture consumes the flag. The flag then leaves the cell along the chain, one bit per clock, during shift. When integrity-select is low, the sensor path plays no part in capture and the cell acts as an ordinary boundary cell. The flag keeps its value until the next integrity capture.

The flag machine has two transitions. `FLAG_CLEAR -> FLAG_SET` happens when the synchronized sensor output is high. `FLAG_SET -> FLAG_CLEAR` happens when an integrity capture occurs and the synchronized sensor output is low in that same cycle. Every other case keeps the current state.

Top module: `si_obs_cell`

## Requirements
- R1: An active-low `trst_n` clears the flag, the synchronizer, the shift stage and the update stage at once. After reset, `scan_out` reads 0 and, with `test_mode`=1, `core_out` reads 0.
- R2: A high level on `sense_pulse` sampled at rising edge k sets the flag at edge k+2, which is the two-stage synchronizer latency.
- R3: Once set, the flag stays at 1 until it is cleared by an integrity capture or by reset. This holds across idle cycles, shift cycles and normal-mode captures.
- R4: At a rising edge with `capture_en`=1, `shift_en`=0 and `integ_sel`=1, the shift stage loads the current flag value, which then appears on `scan_out`.
- R5: The integrity capture of R4 clears the flag, so a second integrity capture with no new sensor activity returns 0.
- R6: If the synchronized sensor output is high in the same cycle as a clearing capture, the set wins and the flag is 1 afterwards.
- R7: At a rising edge with `capture_en`=1, `shift_en`=0 and `integ_sel`=0, the shift stage loads `pin_in`, and the flag is left unchanged.
- R8: At a rising edge with `shift_en`=1, the shift stage loads `scan_in`, whatever the values of `capture_en` and `integ_sel`.
- R9: At a rising edge with `update_en`=1, the update stage loads the shift-stage value. With `test_mode`=1, `core_out` shows the update stage, which holds between updates.
- R10: With `test_mode`=0, `core_out` follows `pin_in` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| scan_in | input | 1 | Serial data from the previous cell |
| scan_out | output | 1 | Shift-stage value toward the next cell |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe; takes priority over capture |
| update_en | input | 1 | Update strobe |
| test_mode | input | 1 | 1 = core side driven by the update stage |
| integ_sel | input | 1 | 1 = capture takes the violation flag |
| sense_pulse | input | 1 | Asynchronous violation pulse from the sensor |
| pin_in | input | 1 | Value arriving from the interconnect |
| core_out | output | 1 | Value presented to the core logic |

## Verification
The bench covers five corner cases.

- **Set coinciding with a clearing capture.** A design with clear priority would lose that violation, so the next capture would read 0 instead of 1.
- **Normal-mode capture after a violation.** A design that cleared the flag on every capture would drop the recorded event.
- **Shift and capture strobes high together.** A design with capture priority would load the pin instead of `scan_in`.
- **Synchronizer latency.** A capture taken one cycle too early must still read 0, so an off-by-one delay shows up.
- **Asynchronous reset with all stages and the flag loaded.** A reset that missed the flag would make the following integrity capture read 1.

// File: rtl/si_cell_pkg.sv
package si_cell_pkg;

    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_SET   = 1'b1
    } flag_state_e;

    typedef enum logic {
        SEL_FLAG  = 1'b0,
        SEL_CHAIN = 1'b1
    } cap_sel_e;

    localparam int MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/si_pulse_sync.sv
module si_pulse_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= async_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[LAST];
endmodule

// File: rtl/si_flag_fsm.sv
module si_flag_fsm
    import si_cell_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic drain_req,
    output logic flag_o
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: if (set_req) state_d = FLAG_SET;
            FLAG_SET:   if (drain_req && !set_req) state_d = FLAG_CLEAR;
            default:    state_d = FLAG_CLEAR;
        endcase
    end

    always_comb begin
        flag_o = (state_q == FLAG_SET);
    end
endmodule

// File: rtl/si_scan_stage.sv
module si_scan_stage
    import si_cell_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ser_i,
    input  logic pin_i,
    input  logic flag_i,
    input  logic cap_i,
    input  logic shf_i,
    input  logic upd_i,
    input  logic integ_i,
    output logic ser_o,
    output logic upd_o
);
    cap_sel_e sel;
    logic     shift_d;
    logic     shift_q;
    logic     hold_q;

    always_comb begin
        sel = (integ_i && !shf_i) ? SEL_FLAG : SEL_CHAIN;
        if (sel == SEL_FLAG) shift_d = flag_i;
        else if (shf_i)      shift_d = ser_i;
        else                 shift_d = pin_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              shift_q <= 1'b0;
        else if (cap_i || shf_i) shift_q <= shift_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hold_q <= 1'b0;
        else if (upd_i) hold_q <= shift_q;
    end

    assign ser_o = shift_q;
    assign upd_o = hold_q;
endmodule

// File: rtl/si_obs_cell.sv
module si_obs_cell #(
    parameter int SYNC_STAGES = 2
) (
    input  logic tck,
    input  logic trst_n,
    input  logic scan_in,
    output logic scan_out,
    input  logic capture_en,
    input  logic shift_en,
    input  logic update_en,
    input  logic test_mode,
    input  logic integ_sel,
    input  logic sense_pulse,
    input  logic pin_in,
    output logic core_out
);
    logic sync_hit;
    logic flag_q;
    logic drain;
    logic upd_q;

    assign drain = capture_en && integ_sel && !shift_en;

    si_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (tck),
        .rst_n   (trst_n),
        .async_i (sense_pulse),
        .sync_o  (sync_hit)
    );

    si_flag_fsm u_flag (
        .clk       (tck),
        .rst_n     (trst_n),
        .set_req   (sync_hit),
        .drain_req (drain),
        .flag_o    (flag_q)
    );

    si_scan_stage u_stage (
        .clk     (tck),
        .rst_n   (trst_n),
        .ser_i   (scan_in),
        .pin_i   (pin_in),
        .flag_i  (flag_q),
        .cap_i   (capture_en),
        .shf_i   (shift_en),
        .upd_i   (update_en),
        .integ_i (integ_sel),
        .ser_o   (scan_out),
        .upd_o   (upd_q)
    );

    assign core_out = test_mode ? upd_q : pin_in;
endmodule

// File: rtl/si_obs_cell_chk.sv
module si_obs_cell_chk (
    input logic tck,
    input logic trst_n,
    input logic scan_in,
    input logic scan_out,
    input logic capture_en,
    input logic shift_en,
    input logic update_en,
    input logic test_mode,
    input logic integ_sel,
    input logic pin_in,
    input logic core_out,
    input logic sync_hit,
    input logic flag_q
);
    assert_flag_set_R2: assert property (@(posedge tck) disable iff (!trst_n)
        sync_hit |=> flag_q);

    assert_flag_sticky_R3: assert property (@(posedge tck) disable iff (!trst_n)
        flag_q && !(capture_en && integ_sel && !shift_en) |=> flag_q);

    assert_integ_capture_R4: assert property (@(posedge tck) disable iff (!trst_n)
        capture_en && integ_sel && !shift_en |=> scan_out == $past(flag_q));

    assert_flag_clear_R5: assert property (@(posedge tck) disable iff (!trst_n)
        capture_en && integ_sel && !shift_en && !sync_hit |=> !flag_q);

    assert_set_priority_R6: assert property (@(posedge tck) disable iff (!trst_n)
        capture_en && integ_sel && !shift_en && sync_hit |=> flag_q);

    assert_normal_capture_R7: assert property (@(posedge tck) disable iff (!trst_n)
        capture_en && !integ_sel && !shift_en |=> scan_out == $past(pin_in));

    assert_shift_R8: assert property (@(posedge tck) disable iff (!trst_n)
        shift_en |=> scan_out == $past(scan_in));

    assert_update_R9: assert property (@(posedge tck) disable iff (!trst_n)
        $past(update_en) && test_mode |-> core_out == $past(scan_out));

    assert_bypass_R10: assert property (@(posedge tck) disable iff (!trst_n)
        !test_mode |-> core_out == pin_in);
endmodule

bind si_obs_cell si_obs_cell_chk u_chk (
    .tck        (tck),
    .trst_n     (trst_n),
    .scan_in    (scan_in),
    .scan_out   (scan_out),
    .capture_en (capture_en),
    .shift_en   (shift_en),
    .update_en  (update_en),
    .test_mode  (test_mode),
    .integ_sel  (integ_sel),
    .pin_in     (pin_in),
    .core_out   (core_out),
    .sync_hit   (sync_hit),
    .flag_q     (flag_q)
);

// File: tb/tb_si_obs_cell.sv
module tb_si_obs_cell;
    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic scan_in = 1'b0, capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0;
    logic test_mode = 1'b0, integ_sel = 1'b0, sense_pulse = 1'b0, pin_in = 1'b0;
    logic scan_out, core_out;

    int checks = 0;
    int fails  = 0;

    always #5 tck = ~tck;

    si_obs_cell dut (
        .tck(tck), .trst_n(trst_n), .scan_in(scan_in), .scan_out(scan_out),
        .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
        .test_mode(test_mode), .integ_sel(integ_sel), .sense_pulse(sense_pulse),
        .pin_in(pin_in), .core_out(core_out)
    );

    // {cap, shf, upd, tm, isel, pin, sin, sense, exp_scan_out, exp_core_out}
    localparam int NVEC = 23;
    localparam logic [9:0] VEC [NVEC] = '{
        10'b0001010000, // 0  idle after reset
        10'b0101011010, // 1  shift a 1
        10'b0011010011, // 2  update
        10'b0100000000, // 3  shift a 0, bypass
        10'b0000010001, // 4  bypass follows pin
        10'b1000010011, // 5  normal capture
        10'b1001110001, // 6  integrity capture, flag empty
        10'b0001000101, // 7  sensor pulse
        10'b0001000001, // 8
        10'b0001000001, // 9  flag sets at this edge
        10'b0001000001, // 10 sticky
        10'b1001000001, // 11 normal capture keeps flag
        10'b1001100011, // 12 integrity capture reads 1
        10'b1001100001, // 13 flag consumed
        10'b1101010001, // 14 shift over capture
        10'b0011010000, // 15 update 0
        10'b0001010000, // 16 update stage holds
        10'b0000010001, // 17 bypass
        10'b0001000100, // 18 pulse again
        10'b0001000000, // 19
        10'b1001100000, // 20 set meets clear
        10'b1001100010, // 21 set won
        10'b1001100000  // 22 consumed
    };

    function automatic string row_req(int i);
        case (i)
            0:               return "R1";
            1, 3, 14:        return "R8";
            2, 15, 16:       return "R9";
            4, 17:           return "R10";
            5, 11:           return "R7";
            6, 13, 22:       return "R5";
            7, 8, 9:         return "R2";
            10:              return "R3";
            12:              return "R4";
            default:         return "R6";
        endcase
    endfunction

    task automatic check_bit(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic drive(logic [7:0] v);
        @(negedge tck);
        {capture_en, shift_en, update_en, test_mode, integ_sel, pin_in, scan_in, sense_pulse} = v;
        @(posedge tck);
        #2;
    endtask

    initial begin
        #1_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        test_mode = 1'b1;
        #22;
        check_bit("R1", "scan_out in reset", scan_out, 1'b0);
        check_bit("R1", "core_out in reset", core_out, 1'b0);
        @(negedge tck);
        trst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][9:2]);
            check_bit(row_req(i), $sformatf("row %0d scan_out", i), scan_out, VEC[i][1]);
            check_bit(row_req(i), $sformatf("row %0d core_out", i), core_out, VEC[i][0]);
        end

        // R2 latency: a capture one edge early still reads 0
        drive(8'b00010001);
        drive(8'b00010000);
        drive(8'b10011000);
        check_bit("R2", "capture before flag set", scan_out, 1'b0);
        drive(8'b10011000);
        check_bit("R2", "capture after flag set", scan_out, 1'b1);

        // R1: asynchronous reset with everything loaded
        drive(8'b01010010);
        drive(8'b00110000);
        drive(8'b00010001);
        drive(8'b00010000);
        drive(8'b00010000);
        check_bit("R1", "preload core_out", core_out, 1'b1);
        @(negedge tck);
        trst_n = 1'b0;
        #2;
        check_bit("R1", "async reset scan_out", scan_out, 1'b0);
        check_bit("R1", "async reset core_out", core_out, 1'b0);
        @(negedge tck);
        trst_n = 1'b1;
        drive(8'b10011000);
        check_bit("R1", "flag cleared by reset", scan_out, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule